// File: doc/BRIEF.md
# Serial Management Bus Master

This block drives a two-wire PHY management bus (clock plus one bidirectional data line) for a host that sees only two 32-bit registers. The control register holds the management clock divider and a preamble enable. It also shows a busy flag. The command register is laid out bit for bit like the serial frame, from the start code down to the 16 data bits. A host write to it while the block is idle sends that word out most significant bit first, after 32 ones if the preamble is enabled.

For a read frame the master releases the data line at the turnaround field. It then samples the PHY's reply on rising management clock edges and places it in the low 16 bits of the command register, where the host reads it once busy has cleared. The management clock is divided down from the system clock. The data line changes only while the management clock is low.

Top module: `mdio_master`

## Requirements
- R1: After reset the control register reads 0x0000_001A (divider 26, preamble off, not busy), `mdc` is low and `mdio_oe` is low.
- R2: A host write with `host_addr[2]`=0 sets the divider from bits [6:0] and the preamble enable from bit 7. Reading at `host_addr[2]`=0 returns the divider in [6:0], the preamble enable in [7] and busy in [8], with zeros above. Bit 8 cannot be written.
- R3: A host write with `host_addr[2]`=1 while idle stores the word and starts a frame. Busy reads 1 from the cycle after that write until the frame ends.
- R4: While a frame runs, `mdc` has a period of 2×(divider+1) system clocks, with each half lasting divider+1 clocks and the low half first. Between frames `mdc` stays low.
- R5: Command bits go out on `mdio_o` from bit 31 down to bit 0, one bit per `mdc` period. `mdio_o` holds steady while `mdc` is high.
- R6: With the preamble enabled, 32 ones precede bit 31 of the command word.
- R7: When command bits [29:28] equal 2 (read), `mdio_oe` drops from command bit 17 to the end of the frame. The value on `mdio_i` at the rising `mdc` edge of command bit n (n ≤ 15) is stored into command register bit n, and bits [31:16] keep their written values.
- R8: For any other opcode (1 = write), `mdio_oe` stays high for the whole frame and the command register reads back unchanged.
- R9: Host writes to either register while busy are ignored.
- R10: A frame lasts exactly (P+32)×2×(divider+1) system clocks, where P is 32 with the preamble enabled and 0 without it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_addr | input | 3 | Host byte address; bit 2 selects the command register |
| host_we | input | 1 | Host write strobe |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, combinational from `host_addr` |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
The assertions assume that the divider cannot change in the middle of a frame. They also assume that nothing outside the block drives the management clock, so that every clock change the block makes comes from its own divider counter. The stimulus keeps to these assumptions: it programs the control register only between frames, and its single attempt to change the divider during a frame is a write that R9 requires the block to drop. The PHY model on the bench drives `mdio_i` only at falling `mdc` edges, so the input is stable at every rising edge where the master samples it.

// File: rtl/mdio_master.sv
`timescale 1ns/1ps
module mdio_master #(
  parameter logic [6:0] DIV_RST = 7'd26,
  parameter int         PRE_LEN = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  host_addr,
  input  logic        host_we,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int CMD_W = 32;
  localparam int IDX_W = $clog2(PRE_LEN + CMD_W + 1);
  localparam logic [IDX_W-1:0] LAST_CMD = IDX_W'(CMD_W - 1);
  localparam logic [IDX_W-1:0] LAST_PRE = IDX_W'(PRE_LEN + CMD_W - 1);

  logic [6:0]       div_q;
  logic             pre_q;
  logic             busy_q;
  logic             mdc_q;
  logic [6:0]       cnt_q;
  logic [IDX_W-1:0] idx_q;
  logic [31:0]      cmd_q;

  wire       sel_cmd  = host_addr[2];
  wire       launch   = host_we && sel_cmd && !busy_q;
  wire       tick     = busy_q && (cnt_q == div_q);
  wire       rd_op    = (cmd_q[29:28] == 2'b10);
  wire       in_pre   = (idx_q >= IDX_W'(CMD_W));
  wire [4:0] bit_sel  = idx_q[4:0];
  wire       rx_phase = rd_op && !in_pre && (idx_q <= IDX_W'(17));
  wire       rx_data  = rx_phase && (idx_q <= IDX_W'(15));

  assign mdc        = mdc_q;
  assign mdio_oe    = busy_q && !rx_phase;
  assign mdio_o     = busy_q && (in_pre || cmd_q[bit_sel]);
  assign host_rdata = sel_cmd ? cmd_q : {23'd0, busy_q, pre_q, div_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= DIV_RST;
      pre_q  <= 1'b0;
      busy_q <= 1'b0;
      mdc_q  <= 1'b0;
      cnt_q  <= '0;
      idx_q  <= '0;
      cmd_q  <= '0;
    end else if (launch) begin
      cmd_q  <= host_wdata;
      busy_q <= 1'b1;
      mdc_q  <= 1'b0;
      cnt_q  <= '0;
      idx_q  <= pre_q ? LAST_PRE : LAST_CMD;
    end else if (host_we && !sel_cmd && !busy_q) begin
      div_q <= host_wdata[6:0];
      pre_q <= host_wdata[7];
    end else if (busy_q) begin
      if (tick) begin
        cnt_q <= '0;
        mdc_q <= !mdc_q;
        if (!mdc_q) begin
          if (rx_data) cmd_q[bit_sel] <= mdio_i;
        end else if (idx_q == '0) begin
          busy_q <= 1'b0;
        end else begin
          idx_q <= idx_q - 1'b1;
        end
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

module mdio_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       mdc,
  input logic       mdio_o,
  input logic       mdio_oe,
  input logic [6:0] div,
  input logic [2:0] host_addr,
  input logic       host_we
);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe));

  a_r5_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> $stable(mdio_o));

  a_r3_start_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(host_we && host_addr[2]));

  a_r4_half_min: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && div != 7'd0 && mdc != $past(mdc)) |=> (mdc == $past(mdc)));

  a_r9_ctrl_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && host_we && !host_addr[2]) |=> (div == $past(div)));

  a_r7_release_low: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(mdio_oe) && busy) |-> !mdc);
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy_q), .mdc(mdc_q), .mdio_o(mdio_o),
  .mdio_oe(mdio_oe), .div(div_q), .host_addr(host_addr), .host_we(host_we)
);

// File: tb/test_mdio_master.sv
`timescale 1ns/1ps
module test_mdio_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  host_addr = 3'd0;
  logic        host_we = 1'b0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = !clk;

  mdio_master i_mdio_master (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_we(host_we),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  int       m_t = 0, m_half = 27, m_n = 32, m_pre = 0;
  bit       m_busy = 0, m_rd = 0, m_pre_en = 0;
  bit [6:0] m_div = 7'd26;
  bit [31:0] m_cmd = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_div = 7'd26; m_pre_en = 0;
    end else if (m_busy) begin
      m_t++;
      if (m_t >= m_n * 2 * m_half) m_busy = 0;
    end else if (host_we && host_addr[2]) begin
      m_cmd  = host_wdata;
      m_rd   = (host_wdata[29:28] == 2'b10);
      m_half = int'(m_div) + 1;
      m_pre  = m_pre_en ? 32 : 0;
      m_n    = m_pre + 32;
      m_t    = 0;
      m_busy = 1;
    end else if (host_we) begin
      m_div    = host_wdata[6:0];
      m_pre_en = host_wdata[7];
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      int k, ci;
      bit e_mdc, e_oe, e_o, ok;
      k     = m_t / (2 * m_half);
      ci    = 31 - (k - m_pre);
      e_mdc = m_busy && (((m_t / m_half) % 2) == 1);
      e_oe  = m_busy && !(m_rd && k >= m_pre && ci <= 17);
      e_o   = (k < m_pre) ? 1'b1 : m_cmd[ci[4:0]];
      ok    = (mdc == e_mdc) && (mdio_oe == e_oe) && (!e_oe || mdio_o == e_o);
      chk(ok, "R4/R5/R7", "per-cycle mdc,oe,o",
          {29'd0, mdc, mdio_oe, mdio_o}, {29'd0, e_mdc, e_oe, e_o});
    end
  end

  // PHY-side model
  bit        rx_q[$];
  int        s_rises = 0;
  int        s_base = 0;
  bit [15:0] s_val = '0;

  always @(posedge mdc) begin
    if (mdio_oe) rx_q.push_back(mdio_o);
    s_rises++;
  end

  always @(negedge mdc) begin
    int j, i;
    j = s_rises - s_base - m_pre;
    i = 31 - j;
    if (j >= 0 && i <= 15 && i >= 0) mdio_i <= s_val[i];
    else if (i == 16) mdio_i <= 1'b0;
    else mdio_i <= 1'b1;
  end

  task automatic host_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    host_addr = a; host_we = 1'b1; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  function automatic logic [31:0] mk(input logic [1:0] op, input logic [4:0] pa,
                                     input logic [4:0] ra, input logic [15:0] d);
    return {2'b01, op, pa, ra, 2'b10, d};
  endfunction

  task automatic run_frame(input bit pre, input logic [6:0] div,
                           input logic [31:0] cmd, input logic [15:0] reply,
                           input bit intrude);
    int cyc, base, nb, p, half;
    bit rd, okb;
    logic [31:0] exp_cmd;
    host_write(3'd0, {24'd0, pre, div});
    rd    = (cmd[29:28] == 2'b10);
    p     = pre ? 32 : 0;
    half  = int'(div) + 1;
    s_val = reply;
    s_base = s_rises;
    base  = rx_q.size();
    host_write(3'd4, cmd);
    host_addr = 3'd0; #1;
    cyc = 0;
    while (host_rdata[8]) begin
      cyc++;
      if (intrude && cyc == 20) begin
        host_we = 1'b1; host_addr = 3'd4; host_wdata = ~cmd;
        @(negedge clk);
        host_addr = 3'd0; host_wdata = 32'h0000_0085;
        @(negedge clk);
        host_we = 1'b0; #1;
        chk(host_rdata[7:0] == {pre, div}, "R9", "ctrl during busy",
            {24'd0, host_rdata[7:0]}, {24'd0, pre, div});
        cyc += 2;
        host_addr = 3'd0;
        @(negedge clk); #1;
      end else begin
        @(negedge clk); #1;
      end
    end
    chk(cyc == (p + 32) * 2 * half, "R10", "frame length",
        cyc, (p + 32) * 2 * half);
    nb = p + (rd ? 14 : 32);
    chk(rx_q.size() - base == nb, rd ? "R7" : "R8", "driven bit count",
        rx_q.size() - base, nb);
    okb = 1;
    for (int b = 0; b < nb && base + b < rx_q.size(); b++) begin
      bit e;
      e = (b < p) ? 1'b1 : cmd[31 - (b - p)];
      if (rx_q[base + b] != e) okb = 0;
    end
    chk(okb, pre ? "R6" : "R5", "bit order", 0, 0);
    exp_cmd = rd ? {cmd[31:16], reply} : cmd;
    host_addr = 3'd4; #1;
    chk(host_rdata == exp_cmd, rd ? "R7" : "R8", "cmd readback",
        host_rdata, exp_cmd);
    host_addr = 3'd0;
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    host_addr = 3'd0; #1;
    chk(host_rdata == 32'h0000_001A, "R1", "ctrl reset", host_rdata, 32'h1A);
    chk(!mdc && !mdio_oe, "R1", "bus idle", {mdc, mdio_oe}, 0);
    host_write(3'd0, 32'hFFFF_FF85);
    host_addr = 3'd0; #1;
    chk(host_rdata == 32'h0000_0085, "R2", "busy not writable",
        host_rdata, 32'h85);
    @(negedge clk);
    host_addr = 3'd0; #1;
    chk(!mdc && !mdio_oe, "R3", "ctrl write starts no frame",
        {mdc, mdio_oe}, 0);
    run_frame(1'b0, 7'd1,  mk(2'b01, 5'h03, 5'h11, 16'hA5C3), 16'h0, 1'b0);
    run_frame(1'b1, 7'd3,  mk(2'b01, 5'h1F, 5'h00, 16'h8001), 16'h0, 1'b0);
    run_frame(1'b1, 7'd26, mk(2'b10, 5'h05, 5'h1E, 16'h0000), 16'hBEEF, 1'b0);
    run_frame(1'b0, 7'd0,  mk(2'b10, 5'h00, 5'h02, 16'hFFFF), 16'h1234, 1'b0);
    run_frame(1'b0, 7'd2,  mk(2'b01, 5'h0A, 5'h15, 16'h5A5A), 16'h0, 1'b1);
    run_frame(1'b0, 7'd127, mk(2'b01, 5'h15, 5'h0A, 16'h0F0F), 16'h0, 1'b0);
    host_addr = 3'd0; #1;
    chk(host_rdata == 32'h0000_007F, "R2", "ctrl after frames",
        host_rdata, 32'h7F);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule